// File: doc/BRIEF.md
# Coprocessor Bus Handover Controller

This block decides who may drive the shared system bus: the host processor or an add-on coprocessor. It keeps two bits of ownership state, a busy flag and a bus-enable flag. Both are updated by byte writes to a control port and by the DRAM-on bit that the host writes into its memory-control register. From bus-enable and the four bank-select lines it produces the system-I/O enable and its complement, the DRAM enable. A status byte that reports the inverted bus-enable next to five pass-through lines can be read back at any time.

A control write with the request bit low hands the bus back. Busy is set, and bus-enable takes the DRAM-on value. A control write with the request bit high and the release bit low clears both flags. While busy is held, bus-enable follows each new DRAM-on value that the host writes. The release bit and the top control bit also drive two interrupt request lines, which hold the value of the last control write.

Top module: `cpbus_handover`

## Requirements
- R1: After reset, the DRAM-on bit, busy and bus-enable are 1. The held control bits give irq_rel = 0 and irq_aux = 0.
- R2: A control write (ctl_wr and ctl_sel high at a rising edge) with ctl_wdata[0] = 0 sets busy to 1. On that same edge, bus-enable takes the DRAM-on value: the new one if the host writes in the same cycle, otherwise the held one.
- R3: A control write with ctl_wdata[0] = 1 and ctl_wdata[6] = 0 clears both busy and bus-enable to 0.
- R4: When a single control write has both ctl_wdata[0] = 0 and ctl_wdata[6] = 0, the R2 action wins.
- R5: A host write (host_wr high) loads host_wdata[4] into the DRAM-on bit. If busy is 1 and no R2 or R3 action happens on that edge, bus-enable takes the new value on the same edge. If busy is 0, bus-enable is left unchanged.
- R6: sysio_en is 1 exactly when bus-enable is 1 and the four bank_sel bits are not all 1. dram_en is always the inverse of sysio_en.
- R7: stat_rdata has bit 0 equal to the inverse of bus-enable, bits 5..1 equal to pass_in[4:0], and bits 7..6 equal to 1. Reading it has no side effects.
- R8: Every control write updates irq_rel to the inverse of ctl_wdata[6] and irq_aux to ctl_wdata[7]. Both hold their values until the next control write.
- R9: A control write with ctl_wdata[0] = 1 and ctl_wdata[6] = 1 leaves busy and bus-enable unchanged. Strobing ctl_wr while ctl_sel is low has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_sel | input | 1 | Control port select |
| ctl_wdata | input | 8 | Control write data |
| host_wr | input | 1 | Host memory-control write strobe |
| host_wdata | input | 8 | Host memory-control data, bit 4 is DRAM-on |
| bank_sel | input | 4 | Bank-select lines |
| pass_in | input | 5 | Lines reflected in the status byte |
| stat_rdata | output | 8 | Status byte |
| sysio_en | output | 1 | System-I/O enable |
| dram_en | output | 1 | DRAM enable |
| irq_rel | output | 1 | Interrupt request, inverse of held control bit 6 |
| irq_aux | output | 1 | Interrupt request, held control bit 7 |

## Verification
A wrong bus-enable shows up in the same cycle on status bit 0 and on the sysio_en/dram_en pair for any bank other than all ones. The busy flag has no port of its own. A wrong busy value stays hidden until the next host DRAM-on write, when bus-enable moves that should have held, or holds that should have moved, one cycle after that write. For this reason the bench follows every control-write pattern with a host write that toggles DRAM-on, and checks bus-enable again.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TAKE = 2'd1,
    ACT_DROP = 2'd2
  } ctl_act_t;

  // Request bit low wins over release bit low.
  function automatic ctl_act_t classify(input logic hit, input logic req_bit,
                                        input logic rel_bit);
    if (!hit)          return ACT_NONE;
    else if (!req_bit) return ACT_TAKE;
    else if (!rel_bit) return ACT_DROP;
    else               return ACT_NONE;
  endfunction

  function automatic logic sysio_term(input logic bank_all_ones, input logic busen);
    return !bank_all_ones && busen;
  endfunction

endpackage

// File: rtl/cpbus_ctl_decode.sv
module cpbus_ctl_decode
  import cpbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REQ_BIT = 0,
  parameter int REL_BIT = 6
) (
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output ctl_act_t          act
);
  always_comb begin
    hit = wr && sel;
    act = classify(hit, wdata[REQ_BIT], wdata[REL_BIT]);
  end
endmodule

// File: rtl/cpbus_own_state.sv
module cpbus_own_state
  import cpbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_act_t act,
  input  logic     host_wr,
  input  logic     host_dram,
  output logic     busy_q,
  output logic     busen_q,
  output logic     dramon_q,
  output logic     track_ev
);
  logic dram_next;

  always_comb begin
    dram_next = host_wr ? host_dram : dramon_q;
    track_ev  = host_wr && busy_q && (act == ACT_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b1;
      busen_q  <= 1'b1;
      dramon_q <= 1'b1;
    end else begin
      dramon_q <= dram_next;
      case (act)
        ACT_TAKE: begin
          busy_q  <= 1'b1;
          busen_q <= dram_next;
        end
        ACT_DROP: begin
          busy_q  <= 1'b0;
          busen_q <= 1'b0;
        end
        default: begin
          if (track_ev) busen_q <= host_dram;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpbus_irq_latch.sv
module cpbus_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rel_bit,
  input  logic aux_bit,
  output logic irq_rel,
  output logic irq_aux
);
  logic rel_q;
  logic aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b1;
      aux_q <= 1'b0;
    end else if (hit) begin
      rel_q <= rel_bit;
      aux_q <= aux_bit;
    end
  end

  assign irq_rel = ~rel_q;
  assign irq_aux = aux_q;
endmodule

// File: rtl/cpbus_enables.sv
module cpbus_enables
  import cpbus_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int PASS_W = 5,
  parameter int DATA_W = 8
) (
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [PASS_W-1:0] pass_in,
  input  logic              busen,
  output logic              sysio_en,
  output logic              dram_en,
  output logic [DATA_W-1:0] stat
);
  localparam int FILL_LO = PASS_W + 1;

  assign sysio_en = sysio_term(&bank_sel, busen);
  assign dram_en  = ~sysio_en;

  assign stat[0]        = ~busen;
  assign stat[PASS_W:1] = pass_in;

  for (genvar i = FILL_LO; i < DATA_W; i++) begin : g_fill
    assign stat[i] = 1'b1;
  end
endmodule

// File: rtl/cpbus_handover.sv
module cpbus_handover
  import cpbus_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 4,
  parameter int PASS_W     = 5,
  parameter int REQ_BIT    = 0,
  parameter int REL_BIT    = 6,
  parameter int AUX_BIT    = 7,
  parameter int DRAMON_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_sel,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [PASS_W-1:0] pass_in,
  output logic [DATA_W-1:0] stat_rdata,
  output logic              sysio_en,
  output logic              dram_en,
  output logic              irq_rel,
  output logic              irq_aux
);
  ctl_act_t act;
  logic     ctl_hit;
  logic     busy_q;
  logic     busen_q;
  logic     dramon_q;
  logic     track_ev;
  logic     unused_bits;

  assign unused_bits = ^{ctl_wdata, host_wdata};

  cpbus_ctl_decode #(.DATA_W(DATA_W), .REQ_BIT(REQ_BIT), .REL_BIT(REL_BIT)) u_dec (
    .wr(ctl_wr), .sel(ctl_sel), .wdata(ctl_wdata), .hit(ctl_hit), .act(act)
  );

  cpbus_own_state u_state (
    .clk(clk), .rst_n(rst_n), .act(act), .host_wr(host_wr),
    .host_dram(host_wdata[DRAMON_BIT]), .busy_q(busy_q), .busen_q(busen_q),
    .dramon_q(dramon_q), .track_ev(track_ev)
  );

  cpbus_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .hit(ctl_hit), .rel_bit(ctl_wdata[REL_BIT]),
    .aux_bit(ctl_wdata[AUX_BIT]), .irq_rel(irq_rel), .irq_aux(irq_aux)
  );

  cpbus_enables #(.BANK_W(BANK_W), .PASS_W(PASS_W), .DATA_W(DATA_W)) u_en (
    .bank_sel(bank_sel), .pass_in(pass_in), .busen(busen_q),
    .sysio_en(sysio_en), .dram_en(dram_en), .stat(stat_rdata)
  );
endmodule

// File: rtl/cpbus_handover_chk.sv
module cpbus_handover_chk #(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 4,
  parameter int PASS_W     = 5,
  parameter int REQ_BIT    = 0,
  parameter int REL_BIT    = 6,
  parameter int AUX_BIT    = 7,
  parameter int DRAMON_BIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_sel,
  input logic [DATA_W-1:0] ctl_wdata,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [BANK_W-1:0] bank_sel,
  input logic [PASS_W-1:0] pass_in,
  input logic [DATA_W-1:0] stat_rdata,
  input logic              sysio_en,
  input logic              dram_en,
  input logic              irq_rel,
  input logic              irq_aux,
  input logic              busy_q,
  input logic              busen_q,
  input logic              dramon_q,
  input logic              track_ev
);
  logic hit;
  logic unused_chk;
  assign hit = ctl_wr && ctl_sel;
  assign unused_chk = ^{ctl_wdata, host_wdata};

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (busy_q && busen_q && dramon_q && !irq_rel && !irq_aux));

  assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctl_wdata[REQ_BIT]) |=> (busy_q && (busen_q == dramon_q)));

  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl_wdata[REQ_BIT] && !ctl_wdata[REL_BIT]) |=> (!busy_q && !busen_q));

  assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctl_wdata[REQ_BIT] && !ctl_wdata[REL_BIT]) |=> busy_q);

  assert_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    track_ev |=> (busen_q == $past(host_wdata[DRAMON_BIT])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !busy_q) |=> $stable(busen_q));

  assert_compl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_en == !sysio_en);

  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bank_sel) || !busen_q) |-> !sysio_en);

  assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[0] != busen_q) && (stat_rdata[PASS_W:1] == pass_in)
    && (&stat_rdata[DATA_W-1:PASS_W+1]));

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> ((irq_rel == !$past(ctl_wdata[REL_BIT])) && (irq_aux == $past(ctl_wdata[AUX_BIT]))));

  assert_noctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(busy_q) && $stable(irq_rel) && $stable(irq_aux)));
endmodule

bind cpbus_handover cpbus_handover_chk #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .PASS_W(PASS_W), .REQ_BIT(REQ_BIT),
  .REL_BIT(REL_BIT), .AUX_BIT(AUX_BIT), .DRAMON_BIT(DRAMON_BIT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
  .host_wr(host_wr), .host_wdata(host_wdata), .bank_sel(bank_sel), .pass_in(pass_in),
  .stat_rdata(stat_rdata), .sysio_en(sysio_en), .dram_en(dram_en), .irq_rel(irq_rel),
  .irq_aux(irq_aux), .busy_q(busy_q), .busen_q(busen_q), .dramon_q(dramon_q),
  .track_ev(track_ev)
);

// File: tb/test_cpbus_handover.sv
module test_cpbus_handover;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, ctl_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h0, host_wdata = 8'h0;
  logic [3:0] bank_sel = 4'h0;
  logic [4:0] pass_in = 5'h0;
  logic [7:0] stat_rdata;
  logic       sysio_en, dram_en, irq_rel, irq_aux;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the requirements
  bit m_busy = 1, m_busen = 1, m_dram = 1, m_irq_rel = 0, m_irq_aux = 0;

  always #5 clk = ~clk;

  cpbus_handover i_cpbus_handover (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
    .host_wr(host_wr), .host_wdata(host_wdata), .bank_sel(bank_sel), .pass_in(pass_in),
    .stat_rdata(stat_rdata), .sysio_en(sysio_en), .dram_en(dram_en),
    .irq_rel(irq_rel), .irq_aux(irq_aux)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [7:0] exp_stat;
    logic exp_sys;
    exp_stat = 8'hC0 | {2'b00, pass_in, 1'b0} | {7'd0, ~m_busen};
    exp_sys  = (bank_sel != 4'hF) && m_busen;
    check(tag, {24'd0, stat_rdata}, {24'd0, exp_stat});
    check(tag, {30'd0, sysio_en, dram_en}, {30'd0, exp_sys, ~exp_sys});
  endtask

  // one clock with the given strobes, model updated per R2..R5, R8, R9
  task automatic step(input bit cw, input bit cs, input logic [7:0] cd,
                      input bit hw, input logic [7:0] hd);
    bit dn;
    @(negedge clk);
    ctl_wr = cw; ctl_sel = cs; ctl_wdata = cd; host_wr = hw; host_wdata = hd;
    @(negedge clk);
    ctl_wr = 0; ctl_sel = 0; host_wr = 0;
    dn = hw ? hd[4] : m_dram;
    if (cw && cs) begin
      m_irq_rel = ~cd[6];
      m_irq_aux = cd[7];
      if (!cd[0]) begin m_busy = 1; m_busen = dn; end
      else if (!cd[6]) begin m_busy = 0; m_busen = 0; end
      else if (hw && m_busy) m_busen = hd[4];
    end else if (hw && m_busy) m_busen = hd[4];
    m_dram = dn;
    #1;
  endtask

  task automatic check_irq(input string tag);
    check(tag, {30'd0, irq_rel, irq_aux}, {30'd0, m_irq_rel, m_irq_aux});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check_outs("R1");
    check_irq("R1");

    // R6/R7 sweep with bus-enable high
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 4; p++) begin
        bank_sel = b[3:0];
        pass_in = (p == 0) ? 5'h00 : (p == 1) ? 5'h1F : (p == 2) ? 5'h15 : 5'h0A;
        #1;
        check_outs(b == 15 ? "R6" : "R7");
      end
    end
    bank_sel = 4'h3;
    pass_in = 5'h12;

    // control-word sweep from three prepared states, then a busy probe
    for (int pre = 0; pre < 3; pre++) begin
      for (int code = 0; code < 8; code++) begin
        for (int sel = 0; sel < 2; sel++) begin
          logic [7:0] cd;
          string tag;
          if (pre == 0) step(1, 1, 8'h40, 1, 8'h10);
          else if (pre == 1) begin step(0, 0, 8'h00, 1, 8'h00); step(1, 1, 8'h40, 0, 8'h00); end
          else step(1, 1, 8'h01, 0, 8'h00);
          cd = {code[2], code[1], 5'b00110, code[0]};
          if (sel == 0) tag = "R9";
          else if (!cd[0] && !cd[6]) tag = "R4";
          else if (!cd[0]) tag = "R2";
          else if (!cd[6]) tag = "R3";
          else tag = "R9";
          step(1, sel[0], cd, 0, 8'h00);
          check_outs(tag);
          check_irq(sel == 1 ? "R8" : "R9");
          // R5: toggle DRAM-on; bus-enable moves only while busy
          step(0, 0, 8'h00, 1, {3'b000, ~m_dram, 4'b0000});
          check_outs("R5");
        end
      end
    end

    // R2: take in the same cycle as a host DRAM-on change
    step(1, 1, 8'h01, 0, 8'h00);
    step(1, 1, 8'hC0, 1, 8'h10);
    check_outs("R2");
    step(1, 1, 8'h40, 1, 8'h00);
    check_outs("R2");
    // R5 with busy clear: host writes leave bus-enable alone
    step(1, 1, 8'h01, 0, 8'h00);
    step(0, 0, 8'h00, 1, 8'h10);
    check_outs("R5");
    // R3 with simultaneous host write still clears
    step(1, 1, 8'h40, 1, 8'h10);
    step(1, 1, 8'h81, 1, 8'h10);
    check_outs("R3");
    check_irq("R8");

    // R6/R7 sweep with bus-enable low
    for (int b = 0; b < 16; b++) begin
      bank_sel = b[3:0];
      pass_in = b[4:0] ^ 5'h0B;
      #1;
      check_outs("R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule